// File: doc/BRIEF.md
# AES Single-Round Execution Unit

This unit computes one AES round on a 128-bit state in a single clock. A caller presents a state operand, a round-key operand and an 8-bit operation code together with `in_valid`. On the next clock edge the unit registers the round result and raises `out_valid` for one cycle. Sequencing several rounds, expanding the key schedule and choosing a cipher mode are left to the caller, who feeds each result back as the next state.

Five operations are supported: a full forward round, a final forward round without column mixing, a full inverse round, a final inverse round without inverse column mixing, and a stand-alone inverse column mix. The inverse column mix prepares round keys for the equivalent inverse cipher. The forward and inverse substitution boxes are built from GF(2^8) inversion and affine maps, so no lookup table is stored. Byte 0 of every 128-bit operand is its least significant byte. Byte `4c+r` holds row `r` of column `c`.

Any operation code outside the five recognised ones raises `out_illegal` for one cycle and leaves the result register untouched.

Top module: `aes_round_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_illegal` are 0 and `out_result` is all zeros.
- R2: An input accepted with a recognised code (0xDB to 0xDF) produces `out_valid` high in exactly the next cycle. Each accepted input gives one valid cycle, and a cycle with `in_valid` low gives no `out_valid` and no `out_illegal` on the following cycle.
- R3: Code 0xDC (full forward round) produces key XOR MixColumns(SubBytes(S)). Here output byte i of S is state byte {0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11}[i]. MixColumns uses coefficients 2,3,1,1, rotated per row.
- R4: Code 0xDD (final forward round) produces key XOR SubBytes(S), with the same byte selection as R3 and no column mixing.
- R5: Code 0xDE (full inverse round) produces key XOR InvMixColumns(InvSubBytes(T)). Here output byte i of T is state byte {0,13,10,7,4,1,14,11,8,5,2,15,12,9,6,3}[i]. InvMixColumns uses coefficients 14,11,13,9, rotated per row.
- R6: Code 0xDF (final inverse round) produces key XOR InvSubBytes(T), with no inverse column mixing.
- R7: Code 0xDB produces InvMixColumns of the key operand alone. The state operand has no effect on the result, and no key XOR is applied.
- R8: An input with any other code raises `out_illegal` for exactly the next cycle, keeps `out_valid` low and leaves `out_result` unchanged. `out_valid` and `out_illegal` are never high together.
- R9: `out_result` changes only on the cycle after an accepted input with a recognised code.
- R10: Feeding the unit the FIPS-197 AES-128 example reproduces the published ciphertext. The caller XORs in round key 0, then runs nine 0xDC rounds and one 0xDD round. The equivalent inverse chain returns the plaintext: round keys 1 to 9 are converted with 0xDB, then nine 0xDE rounds and one 0xDF round are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| in_valid | input | 1 | Operands and code are presented this cycle |
| in_opcode | input | 8 | Operation code (0xDB to 0xDF) |
| in_state | input | 128 | State operand, byte 0 in bits 7:0 |
| in_key | input | 128 | Round-key operand, or the column-mix source for 0xDB |
| out_valid | output | 1 | `out_result` holds a new result this cycle |
| out_illegal | output | 1 | The previous input carried an unknown code |
| out_result | output | 128 | Registered round result |

## Verification
The embedded properties check the handshake on every cycle:
- the one-cycle latency from an accepted input to `out_valid`;
- the single-cycle illegal-code pulse;
- silence after idle cycles;
- that the valid and illegal flags are exclusive;
- that the result register holds whenever nothing legal was accepted.

The round arithmetic itself cannot be expressed as a property. The bench's behavioural model checks it on every clock:
- the byte selection tables;
- the substitution boxes;
- both column-mix matrices;
- the absence of the key XOR for 0xDB;
- state independence under 0xDB.

The two FIPS-197 chains confirm that these pieces compose into a working cipher in both directions.

// File: rtl/aes_round_pkg.sv
`timescale 1ns/1ps
package aes_round_pkg;

  localparam int BYTE_W     = 8;
  localparam int ROWS       = 4;
  localparam int COLS       = 4;
  localparam int NUM_BYTES  = ROWS * COLS;
  localparam int BLOCK_W    = NUM_BYTES * BYTE_W;
  localparam int COL_W      = ROWS * BYTE_W;
  localparam int OPC_W      = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_INVMIX   = 8'hDB,
    OP_ENC      = 8'hDC,
    OP_ENC_LAST = 8'hDD,
    OP_DEC      = 8'hDE,
    OP_DEC_LAST = 8'hDF
  } round_op_e;

  localparam logic [BYTE_W-1:0] FIELD_POLY  = 8'h1B;
  localparam logic [BYTE_W-1:0] FWD_CONST   = 8'h63;
  localparam logic [BYTE_W-1:0] INV_CONST   = 8'h05;
  localparam logic [BYTE_W-1:0] INV_EXP     = 8'hFE;

  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] a);
    gf_dbl = {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? FIELD_POLY : '0);
  endfunction

  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    gf_mul = acc;
  endfunction

  // multiplicative inverse as x^254; zero maps to zero
  function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] r;
    r = 8'h01;
    for (int k = BYTE_W-1; k >= 0; k--) begin
      r = gf_mul(r, r);
      if (INV_EXP[k]) r = gf_mul(r, x);
    end
    gf_inv = r;
  endfunction

  function automatic logic [BYTE_W-1:0] affine_fwd(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] o;
    for (int i = 0; i < BYTE_W; i++) begin
      o[i] = b[i] ^ b[(i+4)%BYTE_W] ^ b[(i+5)%BYTE_W] ^ b[(i+6)%BYTE_W] ^
             b[(i+7)%BYTE_W] ^ FWD_CONST[i];
    end
    affine_fwd = o;
  endfunction

  function automatic logic [BYTE_W-1:0] affine_inv(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] o;
    for (int i = 0; i < BYTE_W; i++) begin
      o[i] = b[(i+2)%BYTE_W] ^ b[(i+5)%BYTE_W] ^ b[(i+7)%BYTE_W] ^ INV_CONST[i];
    end
    affine_inv = o;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
`timescale 1ns/1ps
module aes_sbox
  import aes_round_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [BYTE_W-1:0] in_byte,
  output logic [BYTE_W-1:0] out_byte
);

  generate
    if (INVERSE) begin : g_inverse
      always_comb out_byte = gf_inv(affine_inv(in_byte));
    end else begin : g_forward
      always_comb out_byte = affine_fwd(gf_inv(in_byte));
    end
  endgenerate

endmodule

// File: rtl/aes_mixcol.sv
`timescale 1ns/1ps
module aes_mixcol
  import aes_round_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [COL_W-1:0] col_in,
  output logic [COL_W-1:0] col_out
);

  localparam logic [BYTE_W-1:0] K0 = INVERSE ? 8'h0E : 8'h02;
  localparam logic [BYTE_W-1:0] K1 = INVERSE ? 8'h0B : 8'h03;
  localparam logic [BYTE_W-1:0] K2 = INVERSE ? 8'h0D : 8'h01;
  localparam logic [BYTE_W-1:0] K3 = INVERSE ? 8'h09 : 8'h01;

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int A0 = r;
      localparam int A1 = (r + 1) % ROWS;
      localparam int A2 = (r + 2) % ROWS;
      localparam int A3 = (r + 3) % ROWS;
      always_comb begin
        col_out[r*BYTE_W +: BYTE_W] =
            gf_mul(K0, col_in[A0*BYTE_W +: BYTE_W]) ^
            gf_mul(K1, col_in[A1*BYTE_W +: BYTE_W]) ^
            gf_mul(K2, col_in[A2*BYTE_W +: BYTE_W]) ^
            gf_mul(K3, col_in[A3*BYTE_W +: BYTE_W]);
      end
    end
  endgenerate

endmodule

// File: rtl/aes_round_core.sv
`timescale 1ns/1ps
module aes_round_core
  import aes_round_pkg::*;
(
  input  logic [OPC_W-1:0]   op,
  input  logic [BLOCK_W-1:0] state,
  input  logic [BLOCK_W-1:0] key,
  output logic [BLOCK_W-1:0] result,
  output logic               legal
);

  logic [BLOCK_W-1:0] fwd_shift;
  logic [BLOCK_W-1:0] inv_shift;
  logic [BLOCK_W-1:0] fwd_sub;
  logic [BLOCK_W-1:0] inv_sub;
  logic [BLOCK_W-1:0] fwd_mix;
  logic [BLOCK_W-1:0] imix_src;
  logic [BLOCK_W-1:0] inv_mix;
  logic [BLOCK_W-1:0] pre_key;
  logic               use_key;

  // row rotation: row r of column c comes from column c+r (forward) or c-r (inverse)
  generate
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      localparam int ROW  = i % ROWS;
      localparam int COL  = i / ROWS;
      localparam int FSRC = ((COL + ROW) % COLS) * ROWS + ROW;
      localparam int ISRC = ((COL + COLS - ROW) % COLS) * ROWS + ROW;

      assign fwd_shift[i*BYTE_W +: BYTE_W] = state[FSRC*BYTE_W +: BYTE_W];
      assign inv_shift[i*BYTE_W +: BYTE_W] = state[ISRC*BYTE_W +: BYTE_W];

      aes_sbox #(.INVERSE(1'b0)) u_fwd_sbox (
        .in_byte  (fwd_shift[i*BYTE_W +: BYTE_W]),
        .out_byte (fwd_sub[i*BYTE_W +: BYTE_W])
      );

      aes_sbox #(.INVERSE(1'b1)) u_inv_sbox (
        .in_byte  (inv_shift[i*BYTE_W +: BYTE_W]),
        .out_byte (inv_sub[i*BYTE_W +: BYTE_W])
      );
    end
  endgenerate

  // the stand-alone column mix shares the inverse mixers with the decrypt path
  always_comb imix_src = (op == OP_INVMIX) ? key : inv_sub;

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      aes_mixcol #(.INVERSE(1'b0)) u_fwd_mix (
        .col_in  (fwd_sub[c*COL_W +: COL_W]),
        .col_out (fwd_mix[c*COL_W +: COL_W])
      );

      aes_mixcol #(.INVERSE(1'b1)) u_inv_mix (
        .col_in  (imix_src[c*COL_W +: COL_W]),
        .col_out (inv_mix[c*COL_W +: COL_W])
      );
    end
  endgenerate

  always_comb begin
    pre_key = '0;
    use_key = 1'b1;
    legal   = 1'b1;
    case (op)
      OP_ENC:      pre_key = fwd_mix;
      OP_ENC_LAST: pre_key = fwd_sub;
      OP_DEC:      pre_key = inv_mix;
      OP_DEC_LAST: pre_key = inv_sub;
      OP_INVMIX: begin
        pre_key = inv_mix;
        use_key = 1'b0;
      end
      default: begin
        legal   = 1'b0;
        use_key = 1'b0;
      end
    endcase
  end

  always_comb result = pre_key ^ (use_key ? key : '0);

endmodule

// File: rtl/aes_round_unit.sv
`timescale 1ns/1ps
module aes_round_unit
  import aes_round_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [7:0]     in_opcode,
  input  logic [127:0]   in_state,
  input  logic [127:0]   in_key,
  output logic           out_valid,
  output logic           out_illegal,
  output logic [127:0]   out_result
);

  logic [BLOCK_W-1:0] core_result;
  logic               core_legal;

  logic               valid_d, valid_q;
  logic               illegal_d, illegal_q;
  logic               result_en;
  logic [BLOCK_W-1:0] result_q;

  aes_round_core u_core (
    .op     (in_opcode),
    .state  (in_state),
    .key    (in_key),
    .result (core_result),
    .legal  (core_legal)
  );

  // next-state
  always_comb begin
    valid_d   = in_valid & core_legal;
    illegal_d = in_valid & ~core_legal;
    result_en = valid_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (result_en) begin
      result_q <= core_result;
    end
  end

  assign out_valid   = valid_q;
  assign out_illegal = illegal_q;
  assign out_result  = result_q;

  // port-level view of the recognised code range, kept apart from the core decode
  logic code_in_range;
  assign code_in_range = (in_opcode >= 8'hDB) && (in_opcode <= 8'hDF);

  assert_accept_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && code_in_range) |=> (out_valid && !out_illegal));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_illegal));

  assert_illegal_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !code_in_range) |=> (out_illegal && !out_valid));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_valid, out_illegal}) <= 1);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && code_in_range) |=> $stable(out_result));

endmodule

// File: tb/aes_round_unit_tb.sv
`timescale 1ns/1ps
module aes_round_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [7:0]   in_opcode;
  logic [127:0] in_state;
  logic [127:0] in_key;
  logic         out_valid;
  logic         out_illegal;
  logic [127:0] out_result;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  aes_round_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_opcode   (in_opcode),
    .in_state    (in_state),
    .in_key      (in_key),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_result  (out_result)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] sb  [256];
  logic [7:0] isb [256];
  int fwd_tab [16] = '{0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11};
  int inv_tab [16] = '{0,13,10,7,4,1,14,11,8,5,2,15,12,9,6,3};

  function automatic logic [7:0] mulx(input logic [7:0] a, input logic [7:0] b);
    int p = 0;
    int aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = aa << 1;
      if (aa > 255) aa = (aa ^ 'h11B);
    end
    return p[7:0];
  endfunction

  function automatic logic [127:0] mix_ref(input logic [127:0] v, input bit inverse);
    logic [7:0] cf [4];
    logic [127:0] o;
    if (inverse) cf = '{8'd14, 8'd11, 8'd13, 8'd9};
    else         cf = '{8'd2, 8'd3, 8'd1, 8'd1};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc = 8'h00;
        for (int k = 0; k < 4; k++)
          acc = acc ^ mulx(cf[(k - r + 4) % 4], v[8*(4*c+k) +: 8]);
        o[8*(4*c+r) +: 8] = acc;
      end
    return o;
  endfunction

  function automatic logic [127:0] ref_round(input logic [7:0] op,
                                             input logic [127:0] st,
                                             input logic [127:0] k);
    logic [127:0] t;
    case (op)
      8'hDC, 8'hDD: begin
        for (int i = 0; i < 16; i++) t[8*i +: 8] = sb[st[8*fwd_tab[i] +: 8]];
        if (op == 8'hDC) t = mix_ref(t, 1'b0);
        return t ^ k;
      end
      8'hDE, 8'hDF: begin
        for (int i = 0; i < 16; i++) t[8*i +: 8] = isb[st[8*inv_tab[i] +: 8]];
        if (op == 8'hDE) t = mix_ref(t, 1'b1);
        return t ^ k;
      end
      default: return mix_ref(k, 1'b1);
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'hDC: return "R3";
      8'hDD: return "R4";
      8'hDE: return "R5";
      8'hDF: return "R6";
      8'hDB: return "R7";
      default: return "R8";
    endcase
  endfunction

  logic         exp_valid, exp_illegal;
  logic [127:0] exp_result;
  string        exp_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid   <= 1'b0;
      exp_illegal <= 1'b0;
      exp_result  <= '0;
      exp_tag     <= "R1";
    end else if (in_valid && in_opcode >= 8'hDB && in_opcode <= 8'hDF) begin
      exp_valid   <= 1'b1;
      exp_illegal <= 1'b0;
      exp_result  <= ref_round(in_opcode, in_state, in_key);
      exp_tag     <= tag_of(in_opcode);
    end else begin
      exp_valid   <= 1'b0;
      exp_illegal <= in_valid;
      exp_tag     <= in_valid ? "R8" : "R9";
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      checks++;
      if (out_valid !== exp_valid || out_illegal !== exp_illegal || out_result !== exp_result) begin
        failures++;
        $display("FAIL %s (R2 handshake) valid=%b/%b illegal=%b/%b result=%h expected=%h",
                 exp_tag, out_valid, exp_valid, out_illegal, exp_illegal, out_result, exp_result);
      end
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic do_op(input logic [7:0] op, input logic [127:0] st,
                       input logic [127:0] k, output logic [127:0] res);
    @(negedge clk);
    in_valid  = 1'b1;
    in_opcode = op;
    in_state  = st;
    in_key    = k;
    @(negedge clk);
    in_valid  = 1'b0;
    res       = out_result;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // literal written first byte leftmost -> byte 0 in bits 7:0
  function automatic logic [127:0] from_lit(input logic [127:0] lit);
    logic [127:0] o;
    for (int j = 0; j < 16; j++) o[8*j +: 8] = lit[127-8*j -: 8];
    return o;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(100000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] p, q, x;
    logic [127:0] res, r2, st, k;
    logic [7:0] kb [176];
    logic [7:0] rcon;
    logic [127:0] rk [11];
    logic [127:0] dk [11];
    logic [127:0] pt, ct_exp;

    // substitution tables by the generator walk
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
    for (int i = 0; i < 256; i++) isb[sb[i]] = i[7:0];

    rst_n = 1'b0; in_valid = 1'b0; in_opcode = 8'h00;
    in_state = '0; in_key = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid === 1'b0 && out_illegal === 1'b0, "R1 flags", {126'b0, out_valid, out_illegal}, '0);
    chk(out_result === '0, "R1 result", out_result, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3..R7: each code with random operands
    for (int n = 0; n < 15; n++) begin
      for (int o = 0; o < 5; o++) begin
        do_op(8'hDB + o[7:0], rnd128(), rnd128(), res);
        if (n % 3 == 0) @(negedge clk);
      end
    end

    // special operand patterns
    do_op(8'hDC, '0, '0, res);
    do_op(8'hDE, '1, '0, res);
    do_op(8'hDD, 128'h000102030405060708090a0b0c0d0e0f, '1, res);
    do_op(8'hDF, 128'h000102030405060708090a0b0c0d0e0f, 128'h55, res);

    // R7: state operand has no effect
    k = rnd128();
    do_op(8'hDB, rnd128(), k, res);
    do_op(8'hDB, ~res, k, r2);
    chk(res === r2, "R7 state ignored", r2, res);

    // R8: unknown codes, including direct neighbours of the legal range
    do_op(8'hDC, rnd128(), rnd128(), res);
    do_op(8'hDA, rnd128(), rnd128(), r2);
    chk(r2 === res, "R8 result held", r2, res);
    do_op(8'hE0, rnd128(), rnd128(), r2);
    do_op(8'h00, rnd128(), rnd128(), r2);
    do_op(8'hFF, rnd128(), rnd128(), r2);
    chk(r2 === res, "R8 result held after several", r2, res);

    // R2/R9: back-to-back burst mixing legal and unknown codes, then idle
    @(negedge clk);
    for (int n = 0; n < 24; n++) begin
      in_valid  = 1'b1;
      in_opcode = (n % 7 == 3) ? 8'h42 : 8'hDB + (n % 5);
      in_state  = rnd128();
      in_key    = rnd128();
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_state = rnd128();
    in_opcode = 8'hDC;
    repeat (4) @(negedge clk);

    // R10: FIPS-197 example, key schedule built here
    pt     = from_lit(128'h3243f6a8885a308d313198a2e0370734);
    ct_exp = from_lit(128'h3925841d02dc09fbdc118597196a0b32);
    k      = from_lit(128'h2b7e151628aed2a6abf7158809cf4f3c);
    for (int j = 0; j < 16; j++) kb[j] = k[8*j +: 8];
    rcon = 8'h01;
    for (int w = 4; w < 44; w++) begin
      logic [7:0] t [4];
      for (int b = 0; b < 4; b++) t[b] = kb[4*(w-1)+b];
      if (w % 4 == 0) begin
        logic [7:0] t0;
        t0 = t[0];
        t[0] = sb[t[1]] ^ rcon; t[1] = sb[t[2]]; t[2] = sb[t[3]]; t[3] = sb[t0];
        rcon = mulx(rcon, 8'h02);
      end
      for (int b = 0; b < 4; b++) kb[4*w+b] = kb[4*(w-4)+b] ^ t[b];
    end
    for (int r = 0; r < 11; r++)
      for (int j = 0; j < 16; j++) rk[r][8*j +: 8] = kb[16*r+j];

    st = pt ^ rk[0];
    for (int r = 1; r < 10; r++) begin
      do_op(8'hDC, st, rk[r], res);
      st = res;
    end
    do_op(8'hDD, st, rk[10], res);
    chk(res === ct_exp, "R10 forward chain", res, ct_exp);

    for (int r = 1; r < 10; r++) do_op(8'hDB, '0, rk[r], dk[r]);
    st = ct_exp ^ rk[10];
    for (int r = 9; r >= 1; r--) begin
      do_op(8'hDE, st, dk[r], res);
      st = res;
    end
    do_op(8'hDF, st, rk[0], res);
    chk(res === pt, "R10 inverse chain", res, pt);

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule